// File: doc/BRIEF.md
# Encoded Arithmetic Logic Unit

This block is a purely combinational arithmetic and logic unit of configurable width. A three-bit operation code together with a carry-in bit picks one of twelve results. Eight of them are arithmetic and four are bitwise logic. Every arithmetic result comes from a single adder. Its second operand is formed per bit from B by a small selection term driven by the two low operation bits: the adder sees zero, B, the ones' complement of B, or all ones. The carry-in supplies any "+1".

When the top operation bit is set, the adder result is replaced by a bitwise function of the operands. In that case the carry and overflow flags are cleared. Negative and zero flags always describe the result that leaves the block. A surrounding datapath drives the code and the operands, and takes the result and flags in the same cycle.

Top module: `alu_core`

## Requirements
- R1: With opSel = 3'b000 the result is opA + carryIn, so carryIn=0 gives A and carryIn=1 gives A+1.
- R2: With opSel = 3'b001 the result is opA + opB + carryIn, truncated to W bits.
- R3: With opSel = 3'b010 the result is opA + ~opB + carryIn, so carryIn=1 gives opA - opB.
- R4: With opSel = 3'b011 the result is opA plus all ones plus carryIn, so carryIn=0 gives A-1 and carryIn=1 gives A.
- R5: For any arithmetic code (opSel[2]=0), flagC is the carry out of the most significant adder bit.
- R6: For any arithmetic code, flagV is high exactly when both adder inputs share a sign bit and the result's sign bit differs from it (carry into the MSB XOR carry out of the MSB).
- R7: With opSel[2]=1 the pair {opSel[0], carryIn} picks the logic function: 2'b00 AND, 2'b01 OR, 2'b10 XOR, 2'b11 NOT A. opSel[1] has no effect on the result in this group.
- R8: For logic codes, flagC and flagV are both 0.
- R9: flagN equals result bit W-1 and flagZ is high exactly when every result bit is 0, for all codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 3 | Operation code; bit 2 picks logic, bits 1:0 shape the adder operand or pick the logic function |
| carryIn | input | 1 | Adder carry-in for arithmetic; low bit of the logic function select otherwise |
| opA | input | W | First operand |
| opB | input | W | Second operand |
| result | output | W | Selected result |
| flagC | output | 1 | Carry out of the adder, 0 for logic codes |
| flagV | output | 1 | Signed overflow, 0 for logic codes |
| flagN | output | 1 | Sign bit of the result |
| flagZ | output | 1 | High when the result is all zeros |

## Verification
The checks in the bound checker are immediate comparisons evaluated whenever the inputs change. They assume that opSel, carryIn and both operands are fully known and move together as one operation, because a half-applied code could briefly pair an old operand with a new function. The stimulus therefore changes every input in a single step away from the clock edge. It reads the outputs only half a period later, once the whole adder chain has settled.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    LG_AND = 2'b00,
    LG_OR  = 2'b01,
    LG_XOR = 2'b10,
    LG_NOT = 2'b11
  } logicOp_e;

  typedef struct packed {
    logic     isLogic;   // select bitwise group instead of adder
    logic     passTrue;  // operand term keeps B where B is 1
    logic     passInv;   // operand term keeps ~B where B is 0
    logic     addOne;    // adder carry-in
    logicOp_e logicOp;   // bitwise function
  } aluStrobes_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [2:0]  opSel,
  input  logic        carryIn,
  output aluStrobes_t strobes
);

  always_comb begin
    strobes          = '0;
    strobes.isLogic  = opSel[2];
    strobes.passTrue = opSel[0];
    strobes.passInv  = opSel[1];
    strobes.addOne   = carryIn & ~opSel[2];
    unique case ({opSel[0], carryIn})
      2'b00:   strobes.logicOp = LG_AND;
      2'b01:   strobes.logicOp = LG_OR;
      2'b10:   strobes.logicOp = LG_XOR;
      default: strobes.logicOp = LG_NOT;
    endcase
  end

endmodule

// File: rtl/alu_operand_sel.sv
module alu_operand_sel #(
  parameter int W = 8
) (
  input  logic [W-1:0] opB,
  input  logic         passTrue,
  input  logic         passInv,
  output logic [W-1:0] addB
);

  // per bit: y = b&s0 | ~b&s1
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign addB[i] = (opB[i] & passTrue) | (~opB[i] & passInv);
  end

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         carryIntoMsb,
  output logic         carryOut
);

  logic [W:0] chain;

  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_fa
    logic gen, prop;
    assign gen         = x[i] & y[i];
    assign prop        = x[i] ^ y[i];
    assign sum[i]      = prop ^ chain[i];
    assign chain[i+1]  = gen | (prop & chain[i]);
  end

  assign carryIntoMsb = chain[W-1];
  assign carryOut     = chain[W];

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logicOp_e     logicOp,
  output logic [W-1:0] logicOut
);

  always_comb begin
    unique case (logicOp)
      LG_AND:  logicOut = opA & opB;
      LG_OR:   logicOut = opA | opB;
      LG_XOR:  logicOut = opA ^ opB;
      default: logicOut = ~opA;
    endcase
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  aluStrobes_t  strobes,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] result,
  output logic         flagC,
  output logic         flagV,
  output logic         flagN,
  output logic         flagZ
);

  logic [W-1:0] addB;
  logic [W-1:0] sumOut;
  logic [W-1:0] logicOut;
  logic         carryIntoMsb;
  logic         carryOut;

  alu_operand_sel #(.W(W)) opsel_i (
    .opB      (opB),
    .passTrue (strobes.passTrue),
    .passInv  (strobes.passInv),
    .addB     (addB)
  );

  alu_adder #(.W(W)) adder_i (
    .x            (opA),
    .y            (addB),
    .cin          (strobes.addOne),
    .sum          (sumOut),
    .carryIntoMsb (carryIntoMsb),
    .carryOut     (carryOut)
  );

  alu_logic #(.W(W)) logic_i (
    .opA      (opA),
    .opB      (opB),
    .logicOp  (strobes.logicOp),
    .logicOut (logicOut)
  );

  always_comb begin
    if (strobes.isLogic) begin
      result = logicOut;
      flagC  = 1'b0;
      flagV  = 1'b0;
    end else begin
      result = sumOut;
      flagC  = carryOut;
      flagV  = carryIntoMsb ^ carryOut;
    end
  end

  assign flagN = result[W-1];
  assign flagZ = ~|result;

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [2:0]   opSel,
  input  logic         carryIn,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] result,
  output logic         flagC,
  output logic         flagV,
  output logic         flagN,
  output logic         flagZ
);

  aluStrobes_t strobes;

  alu_decode decode_i (
    .opSel   (opSel),
    .carryIn (carryIn),
    .strobes (strobes)
  );

  alu_datapath #(.W(W)) dp_i (
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .result  (result),
    .flagC   (flagC),
    .flagV   (flagV),
    .flagN   (flagN),
    .flagZ   (flagZ)
  );

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int W = 8
) (
  input logic [2:0]   opSel,
  input logic         carryIn,
  input logic [W-1:0] opA,
  input logic [W-1:0] opB,
  input logic [W-1:0] result,
  input logic         flagC,
  input logic         flagV,
  input logic         flagN,
  input logic         flagZ
);

  always_comb begin
    if (opSel == 3'b000)
      AST_PASS_INC: assert (result == W'(opA + W'(carryIn))); // R1
    if (opSel == 3'b011)
      AST_DEC_PASS: assert (result == W'(opA - W'(!carryIn))); // R4
    if (opSel == 3'b001)
      AST_ADD_OVF: assert (flagV == ((opA[W-1] == opB[W-1]) && (result[W-1] != opA[W-1]))); // R6
    if (opSel[2] && opSel[0] && carryIn)
      AST_NOT_A: assert (result == ~opA); // R7
    if (opSel[2])
      AST_LOGIC_FLAGS: assert (!flagC && !flagV); // R8
    AST_SIGN_ZERO: assert (flagN == result[W-1] && flagZ == (result == '0)); // R9
  end

endmodule

bind alu_core alu_core_chk #(.W(W)) chk_i (
  .opSel   (opSel),
  .carryIn (carryIn),
  .opA     (opA),
  .opB     (opB),
  .result  (result),
  .flagC   (flagC),
  .flagV   (flagV),
  .flagN   (flagN),
  .flagZ   (flagZ)
);

// File: tb/alu_core_tb_top.sv
module alu_core_tb_top;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic [2:0]   opSel = '0;
  logic         carryIn = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [W-1:0] result;
  logic         flagC, flagV, flagN, flagZ;

  int  nRun = 0;
  int  nFail = 0;
  bit  finished = 0;

  always #5 clk = ~clk;

  alu_core #(.W(W)) dut_i (
    .opSel   (opSel),
    .carryIn (carryIn),
    .opA     (opA),
    .opB     (opB),
    .result  (result),
    .flagC   (flagC),
    .flagV   (flagV),
    .flagN   (flagN),
    .flagZ   (flagZ)
  );

  task automatic checkBit(string tag, string what, logic act, logic exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // Apply one operation, compute reference from the requirement text, compare.
  task automatic runOp(string tag, logic [2:0] op, logic ci,
                       logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] yv, expR;
    logic [W:0]   wide;
    logic         expC, expV;
    @(posedge clk);
    #1;
    opSel = op; carryIn = ci; opA = a; opB = b;
    if (!op[2]) begin
      case (op[1:0])
        2'b00:   yv = '0;
        2'b01:   yv = b;
        2'b10:   yv = ~b;
        default: yv = '1;
      endcase
      wide = {1'b0, a} + {1'b0, yv} + {{W{1'b0}}, ci};
      expR = wide[W-1:0];
      expC = wide[W];
      expV = (a[W-1] == yv[W-1]) && (expR[W-1] != a[W-1]);
    end else begin
      case ({op[0], ci})
        2'b00:   expR = a & b;
        2'b01:   expR = a | b;
        2'b10:   expR = a ^ b;
        default: expR = ~a;
      endcase
      expC = 1'b0;
      expV = 1'b0;
    end
    @(negedge clk);
    nRun++;
    if (result !== expR) begin
      nFail++;
      $display("FAIL %s result op=%b cin=%b a=%h b=%h actual=%h expected=%h",
               tag, op, ci, a, b, result, expR);
    end
    checkBit(op[2] ? "R8" : "R5", "flagC", flagC, expC);
    checkBit(op[2] ? "R8" : "R6", "flagV", flagV, expV);
    checkBit("R9", "flagN", flagN, expR[W-1]);
    checkBit("R9", "flagZ", flagZ, (expR == '0));
  endtask

  task automatic testIdle();
    runOp("R9", 3'b000, 1'b0, 8'h00, 8'h00);
  endtask

  task automatic testTransfer(); // R1
    runOp("R1", 3'b000, 1'b0, 8'h5A, 8'hFF);
    runOp("R1", 3'b000, 1'b1, 8'h7F, 8'h00);
    runOp("R1", 3'b000, 1'b1, 8'hFF, 8'h12);
  endtask

  task automatic testAdd(); // R2 R5 R6
    runOp("R2", 3'b001, 1'b0, 8'h12, 8'h34);
    runOp("R2", 3'b001, 1'b1, 8'h7F, 8'h00);
    runOp("R2", 3'b001, 1'b0, 8'h80, 8'h80);
    runOp("R2", 3'b001, 1'b1, 8'hFF, 8'hFF);
  endtask

  task automatic testSub(); // R3
    runOp("R3", 3'b010, 1'b1, 8'h50, 8'h20);
    runOp("R3", 3'b010, 1'b1, 8'h20, 8'h50);
    runOp("R3", 3'b010, 1'b1, 8'h80, 8'h01);
    runOp("R3", 3'b010, 1'b0, 8'h33, 8'h33);
    runOp("R3", 3'b010, 1'b1, 8'h44, 8'h44);
  endtask

  task automatic testDec(); // R4
    runOp("R4", 3'b011, 1'b0, 8'h80, 8'h9C);
    runOp("R4", 3'b011, 1'b0, 8'h00, 8'h00);
    runOp("R4", 3'b011, 1'b1, 8'hA5, 8'h3C);
  endtask

  task automatic testLogic(); // R7 R8
    for (int s1 = 0; s1 < 2; s1++) begin
      runOp("R7", {1'b1, 1'(s1), 1'b0}, 1'b0, 8'hCC, 8'hAA);
      runOp("R7", {1'b1, 1'(s1), 1'b0}, 1'b1, 8'hCC, 8'hAA);
      runOp("R7", {1'b1, 1'(s1), 1'b1}, 1'b0, 8'hCC, 8'hAA);
      runOp("R7", {1'b1, 1'(s1), 1'b1}, 1'b1, 8'hCC, 8'hAA);
    end
    runOp("R8", 3'b110, 1'b0, 8'hFF, 8'hFF);
    runOp("R8", 3'b111, 1'b1, 8'hFF, 8'h00);
  endtask

  task automatic testSweep(); // R2 R3 R5 R6
    for (int k = 0; k < 16; k++) begin
      runOp("R6", 3'b001, k[0], 8'(k * 37), 8'(k * 91 + 5));
      runOp("R5", 3'b010, k[1], 8'(k * 53 + 7), 8'(k * 29));
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    testIdle();
    testTransfer();
    testAdd();
    testSub();
    testDec();
    testLogic();
    testSweep();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      nRun++;
      nFail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule